// File: doc/BRIEF.md
# Frame Store Register Port

This block decodes a single-cycle internal register bus. It holds four read/write scratch registers, four read-only identity words, and an indirect access path into a double-buffered 32x32 pixel store.

The host first writes a starting location to the pointer register. It then streams 12-bit pixels through the data register. After each pixel write the pointer steps forward by one. The pointer holds the buffer in bit 10, the row in bits 9:5 and the column in bits 4:0. Each pixel is steered to one of two external half-display memories: rows 0-15 go to the upper memory and rows 16-31 go to the lower one. Because of this split, a scan engine can fetch a pixel from each half in the same cycle.

A select register picks which of the two buffers the scan engine shows. Read data is registered and appears one cycle after the read strobe.

Top module: `fb_regport`

## Requirements
- R1: After reset, `rdata_o` is 0, both memory write enables are low, `disp_sel_o` is 0, and a read of address 0x8 returns 0.
- R2: Addresses 0x0-0x3 are scratch registers that reset to 0. A read returns the full 16-bit value last written.
- R3: Addresses 0x4-0x7 return the constants `ID_VALS[0]` to `ID_VALS[3]`. A write to them changes nothing.
- R4: A write to 0x8 loads the 11-bit pointer from `wdata_i[10:0]`. A read of 0x8 returns the pointer zero-extended to 16 bits.
- R5: A write to 0x9 raises exactly one memory write enable for one cycle, in the cycle after the strobe. The write carries `wdata_i[11:0]`, so bits 15:12 are ignored. The pointer then advances by one.
- R6: A pointer with bit 9 equal to 0 writes the upper-half memory, and bit 9 equal to 1 writes the lower-half memory. The 10-bit memory address is {pointer[10], pointer[8:0]}.
- R7: The pointer wraps from 0x7FF to 0x000 on a pixel write.
- R8: A write to 0xA sets `disp_sel_o` to `wdata_i[0]` in the next cycle, and nothing else changes it. A read of 0xA returns the displayed buffer in bit 0.
- R9: A read of 0x9, or of any address from 0xB up, returns 0. A write to any address from 0xB up changes no register.
- R10: `rdata_o` is 0 in every cycle that does not directly follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, one cycle after `rd_i` |
| disp_sel_o | output | 1 | Buffer chosen for display |
| top_we_o | output | 1 | Upper-half memory write enable |
| top_addr_o | output | HAW | Upper-half memory address |
| top_data_o | output | PIX_W | Upper-half memory write data |
| bot_we_o | output | 1 | Lower-half memory write enable |
| bot_addr_o | output | HAW | Lower-half memory address |
| bot_data_o | output | PIX_W | Lower-half memory write data |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it:
- read data,
- the half-memory write enable with its address and data,
- the select output.

The pointer's new value is visible to the next access, which is either a pixel write or a read of 0x8. The bench drives each access on a falling edge and updates its behavioural model for the following rising edge. It then compares every output 1 ns after that edge. Back-to-back pixel writes are issued to show the pointer advancing at the rate of one write per cycle, including the crossing from row 15 into row 16 and the wrap at 0x7FF.

// File: rtl/fb_regport_pkg.sv
package fb_regport_pkg;
  localparam int N_SCR_DEF = 4;
  localparam int N_RO_DEF  = 4;
  localparam int PIX_W_DEF = 12;
  localparam int COL_BITS_DEF = 5;
  localparam int ROW_BITS_DEF = 5;
endpackage

// File: rtl/fb_scratch_bank.sv
module fb_scratch_bank #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int N_SCR = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [N_SCR-1:0][DW-1:0] regs_o
);
  for (genvar g = 0; g < N_SCR; g++) begin : g_reg
    logic hit;
    assign hit = wr_i && (addr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_o[g] <= '0;
      else if (hit) regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/fb_pix_steer.sv
module fb_pix_steer #(
  parameter int PIX_W    = 12,
  parameter int COL_BITS = 5,
  parameter int ROW_BITS = 5,
  localparam int PTR_W   = 1 + ROW_BITS + COL_BITS,
  localparam int HAW     = PTR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_ld_i,
  input  logic [PTR_W-1:0] ptr_val_i,
  input  logic             pix_wr_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             top_we_o,
  output logic             bot_we_o,
  output logic [HAW-1:0]   mem_addr_o,
  output logic [PIX_W-1:0] mem_data_o
);
  localparam int HB = COL_BITS + ROW_BITS - 1;  // row MSB picks the half

  logic [PTR_W-1:0] ptr_q;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      top_we_o   <= 1'b0;
      bot_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      top_we_o <= 1'b0;
      bot_we_o <= 1'b0;
      if (ptr_ld_i) begin
        ptr_q <= ptr_val_i;
      end else if (pix_wr_i) begin
        top_we_o   <= !ptr_q[HB];
        bot_we_o   <= ptr_q[HB];
        mem_addr_o <= {ptr_q[PTR_W-1], ptr_q[HB-1:0]};
        mem_data_o <= pix_i;
        ptr_q      <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fb_read_mux.sv
module fb_read_mux #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int N_SCR = 4,
  parameter int N_RO  = 4,
  parameter int PTR_W = 11,
  parameter logic [N_RO-1:0][DW-1:0] ID_VALS = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [N_SCR-1:0][DW-1:0] scr_i,
  input  logic [PTR_W-1:0]         ptr_i,
  input  logic                     sel_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int RO_BASE = N_SCR;
  localparam int A_PTR   = N_SCR + N_RO;
  localparam int A_SEL   = A_PTR + 2;

  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < N_SCR; i++)
      if (addr_i == AW'(i)) rd_d = scr_i[i];
    for (int i = 0; i < N_RO; i++)
      if (addr_i == AW'(RO_BASE + i)) rd_d = ID_VALS[i];
    if (addr_i == AW'(A_PTR)) rd_d = DW'(ptr_i);
    if (addr_i == AW'(A_SEL)) rd_d = DW'(sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_d;
    else           rdata_o <= '0;
  end
endmodule

// File: rtl/fb_regport.sv
module fb_regport
  import fb_regport_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int N_SCR    = N_SCR_DEF,
  parameter int N_RO     = N_RO_DEF,
  parameter int PIX_W    = PIX_W_DEF,
  parameter int COL_BITS = COL_BITS_DEF,
  parameter int ROW_BITS = ROW_BITS_DEF,
  parameter logic [N_RO-1:0][DW-1:0] ID_VALS = {16'h7E57, 16'h0C0D, 16'h0F1E, 16'hB00C},
  localparam int PTR_W   = 1 + ROW_BITS + COL_BITS,
  localparam int HAW     = PTR_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             disp_sel_o,
  output logic             top_we_o,
  output logic [HAW-1:0]   top_addr_o,
  output logic [PIX_W-1:0] top_data_o,
  output logic             bot_we_o,
  output logic [HAW-1:0]   bot_addr_o,
  output logic [PIX_W-1:0] bot_data_o
);
  localparam int A_PTR = N_SCR + N_RO;
  localparam int A_PIX = A_PTR + 1;
  localparam int A_SEL = A_PTR + 2;

  logic                     ptr_ld, pix_wr, sel_wr;
  logic [N_SCR-1:0][DW-1:0] scr;
  logic [PTR_W-1:0]         ptr;
  logic [HAW-1:0]           mem_addr;
  logic [PIX_W-1:0]         mem_data;
  logic                     sel_q;

  assign ptr_ld = wr_i && (addr_i == AW'(A_PTR));
  assign pix_wr = wr_i && (addr_i == AW'(A_PIX));
  assign sel_wr = wr_i && (addr_i == AW'(A_SEL));

  fb_scratch_bank #(.AW(AW), .DW(DW), .N_SCR(N_SCR)) u_scr (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .regs_o(scr)
  );

  fb_pix_steer #(.PIX_W(PIX_W), .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_steer (
    .clk_i, .rst_ni,
    .ptr_ld_i(ptr_ld), .ptr_val_i(wdata_i[PTR_W-1:0]),
    .pix_wr_i(pix_wr), .pix_i(wdata_i[PIX_W-1:0]),
    .ptr_o(ptr), .top_we_o, .bot_we_o,
    .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (sel_wr) sel_q <= wdata_i[0];
  end

  fb_read_mux #(.AW(AW), .DW(DW), .N_SCR(N_SCR), .N_RO(N_RO), .PTR_W(PTR_W),
                .ID_VALS(ID_VALS)) u_rmux (
    .clk_i, .rst_ni, .rd_i, .addr_i, .scr_i(scr), .ptr_i(ptr), .sel_i(sel_q),
    .rdata_o
  );

  assign disp_sel_o = sel_q;
  assign top_addr_o = mem_addr;
  assign top_data_o = mem_data;
  assign bot_addr_o = mem_addr;
  assign bot_data_o = mem_data;
endmodule

// File: rtl/fb_regport_chk.sv
module fb_regport_chk #(
  parameter int AW = 16, parameter int DW = 16, parameter int N_SCR = 4,
  parameter int N_RO = 4, parameter int PIX_W = 12, parameter int HAW = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             disp_sel_o,
  input logic             top_we_o,
  input logic [HAW-1:0]   top_addr_o,
  input logic [PIX_W-1:0] top_data_o,
  input logic             bot_we_o,
  input logic [HAW-1:0]   bot_addr_o,
  input logic [PIX_W-1:0] bot_data_o
);
  localparam int A_PTR = N_SCR + N_RO;
  localparam int A_PIX = A_PTR + 1;
  localparam int A_SEL = A_PTR + 2;
  localparam int PW    = HAW + 1;

  logic             pix_wr, sel_wr, any_we;
  logic [HAW-1:0]   cur_addr;
  logic [PIX_W-1:0] cur_data;
  logic [PW-1:0]    full_ptr;

  assign pix_wr   = wr_i && (addr_i == AW'(A_PIX));
  assign sel_wr   = wr_i && (addr_i == AW'(A_SEL));
  assign any_we   = top_we_o || bot_we_o;
  assign cur_addr = top_we_o ? top_addr_o : bot_addr_o;
  assign cur_data = top_we_o ? top_data_o : bot_data_o;
  assign full_ptr = {cur_addr[HAW-1], bot_we_o, cur_addr[HAW-2:0]};

  AST_PIX_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_wr |=> $onehot({top_we_o, bot_we_o})); // R5
  AST_NO_STRAY_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_wr |=> !any_we); // R5
  AST_PIX_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_wr |=> cur_data == $past(wdata_i[PIX_W-1:0])); // R5
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_we && $past(any_we)) |-> full_ptr == $past(full_ptr) + PW'(1)); // R7
  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> disp_sel_o == $past(wdata_i[0])); // R8
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(disp_sel_o)); // R8
  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i > AW'(A_SEL) || addr_i == AW'(A_PIX))) |=> rdata_o == '0); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0); // R10
endmodule

bind fb_regport fb_regport_chk #(
  .AW(AW), .DW(DW), .N_SCR(N_SCR), .N_RO(N_RO), .PIX_W(PIX_W), .HAW(HAW)
) u_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .disp_sel_o,
  .top_we_o, .top_addr_o, .top_data_o, .bot_we_o, .bot_addr_o, .bot_data_o
);

// File: tb/fb_regport_tb.sv
`timescale 1ns/1ps
module fb_regport_tb;
  localparam logic [3:0][15:0] IDS = {16'hC0DE, 16'h5A5A, 16'h0F1E, 16'hB00C};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] rdata_o;
  logic        disp_sel_o, top_we_o, bot_we_o;
  logic [9:0]  top_addr_o, bot_addr_o;
  logic [11:0] top_data_o, bot_data_o;

  fb_regport #(.ID_VALS(IDS)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 0;
  int m_scr[4];
  int m_ptr = 0, m_sel = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a < 4) return m_scr[a];
    if (a < 8) return int'(IDS[a-4]);
    if (a == 8) return m_ptr;
    if (a == 10) return m_sel;
    return 0;
  endfunction

  task automatic op(input bit w, input bit r, input int a, input int d, input string tag);
    int e_rd, e_addr, e_data;
    bit e_pix, e_half;
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = a[15:0]; wdata_i = d[15:0];
    e_rd   = r ? model_read(a) : 0;
    e_pix  = w && a == 9;
    e_half = ((m_ptr >> 9) & 1) == 1;
    e_addr = (((m_ptr >> 10) & 1) << 9) | (m_ptr & 'h1ff);
    e_data = d & 'hfff;
    if (w) begin
      if (a < 4) m_scr[a] = d & 'hffff;
      else if (a == 8) m_ptr = d & 'h7ff;
      else if (a == 9) m_ptr = (m_ptr + 1) & 'h7ff;
      else if (a == 10) m_sel = d & 1;
    end
    @(posedge clk_i); #1;
    wr_i = 1'b0; rd_i = 1'b0;
    chk(int'(rdata_o) == e_rd, r ? tag : "R10", int'(rdata_o), e_rd);
    chk(top_we_o == (e_pix && !e_half), e_pix ? tag : "R5", int'(top_we_o), int'(e_pix && !e_half));
    chk(bot_we_o == (e_pix && e_half), e_pix ? tag : "R5", int'(bot_we_o), int'(e_pix && e_half));
    if (e_pix) begin
      chk(int'(e_half ? bot_addr_o : top_addr_o) == e_addr, tag,
          int'(e_half ? bot_addr_o : top_addr_o), e_addr);
      chk(int'(e_half ? bot_data_o : top_data_o) == e_data, tag,
          int'(e_half ? bot_data_o : top_data_o), e_data);
    end
    chk(int'(disp_sel_o) == m_sel, "R8", int'(disp_sel_o), m_sel);
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (m_scr[i]) m_scr[i] = 0;
    #20;
    // R1 reset state
    chk(rdata_o == 0, "R1", int'(rdata_o), 0);
    chk(!top_we_o && !bot_we_o, "R1", int'({top_we_o, bot_we_o}), 0);
    chk(disp_sel_o == 0, "R1", int'(disp_sel_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    op(0, 1, 8, 0, "R1");
    // R2 scratch
    for (int i = 0; i < 4; i++) op(0, 1, i, 0, "R2");
    op(1, 0, 0, 'h1357, "R2"); op(1, 0, 1, 'hFFFF, "R2");
    op(1, 0, 2, 'h8001, "R2"); op(1, 0, 3, 'h00A0, "R2");
    for (int i = 0; i < 4; i++) op(0, 1, i, 0, "R2");
    op(1, 0, 2, 'h4242, "R2"); op(0, 1, 2, 0, "R2");
    // R3 identity words, writes ignored
    for (int i = 4; i < 8; i++) op(0, 1, i, 0, "R3");
    op(1, 0, 5, 'hDEAD, "R3"); op(0, 1, 5, 0, "R3");
    // R4 pointer load and readback, 11-bit mask
    op(1, 0, 8, 'h0123, "R4"); op(0, 1, 8, 0, "R4");
    op(1, 0, 8, 'hFFFF, "R4"); op(0, 1, 8, 0, "R4");
    // R5/R6 pixel writes, upper-half then crossing into lower half
    op(1, 0, 8, 'h01FE, "R6");
    op(1, 0, 9, 'hFABC, "R5");
    op(1, 0, 9, 'h0321, "R6");
    op(1, 0, 9, 'h0456, "R6");
    op(0, 1, 8, 0, "R5");
    op(1, 0, 8, 'h0400, "R6"); op(1, 0, 9, 'h0777, "R6");
    op(1, 0, 8, 'h061F, "R6"); op(1, 0, 9, 'h0888, "R6");
    // R7 wrap
    op(1, 0, 8, 'h07FF, "R7");
    op(1, 0, 9, 'h0111, "R7"); op(1, 0, 9, 'h0222, "R7");
    op(0, 1, 8, 0, "R7");
    // R8 select
    op(0, 1, 10, 0, "R8");
    op(1, 0, 10, 1, "R8"); op(0, 1, 10, 0, "R8");
    op(1, 0, 0, 'h0, "R8");
    op(1, 0, 10, 2, "R8"); op(0, 1, 10, 0, "R8");
    op(1, 0, 10, 1, "R8");
    // R9 unmapped
    op(0, 1, 9, 0, "R9"); op(0, 1, 11, 0, "R9");
    op(0, 1, 15, 0, "R9"); op(0, 1, 'h100, 0, "R9");
    op(1, 0, 11, 'hFFFF, "R9"); op(1, 0, 'h108, 'h0055, "R9");
    op(1, 0, 'h10A, 'h0000, "R9");
    for (int i = 0; i < 4; i++) op(0, 1, i, 0, "R9");
    op(0, 1, 8, 0, "R9"); op(0, 1, 10, 0, "R9");
    // R10 idle cycles
    op(0, 0, 0, 0, "R10"); op(0, 0, 4, 0, "R10");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule